// File: doc/BRIEF.md
# Locked Read-Modify-Write Sequencer

This block carries out one locked read-modify-write at a time for a core that owns a private, coherent L1 cache. The core presents an address, a size code, an operation code and one or two operands. The block reads the bytes it needs from the cache, computes the result and writes it back. It then returns the previous value together with a success flag. Ordinary aligned loads and stores of up to eight bytes that stay inside one line never come here.

Atomicity is reached in one of two ways. If the addressed bytes stay inside one 64-byte line, the block first asks the cache to hold that line in an owned (Modified or Exclusive) state. From its first read through its last write it stalls every coherency snoop aimed at that line. Stalled snoops are taken in arrival order once the write is done. If the bytes run over a line boundary, the block asks for the system bus lock and waits for the grant. It then raises LOCK, reads both lines, writes both lines, and drops LOCK only after the second write has been acknowledged. While LOCK is high, bus requests from other agents are refused.

Top module: `rmw_lock_ctrl`

## Requirements
- R1: `req_ready` is high only when no operation is in progress. A request is taken on a clock edge where `req_valid` and `req_ready` are both high, and `req_ready` stays low until the response has been given.
- R2: An operation whose bytes lie inside one line raises `l1_own_req` for that line and waits for `l1_own_gnt` before its read. It never raises `bus_lock_req` or `lock_out`.
- R3: An operation is line-crossing when byte offset plus byte count is greater than 64. It raises `bus_lock_req` and waits for `bus_lock_gnt`. `lock_out` is high only while the grant is present. The operation reads the lower line and then the next line, and writes them in the same order.
- R4: For a line-crossing operation, `lock_out` is still high at the acknowledge of the last write and falls in the cycle after it.
- R5: `agent_gnt` is low whenever `lock_out` is high. Otherwise it follows `agent_req`.
- R6: While the L1 port is busy with a read or a write of the operation, `snp_ready` is low for a snoop whose line equals a locked line (the line holding the access, plus the next line when the access crosses). It stays high for any other line and whenever the block is idle.
- R7: Operation code 0 (add) stores old plus operand, truncated to the access size, and returns the old value.
- R8: Operation code 1 (exchange) stores the operand and returns the old value. `rsp_success` is 1 for codes 0 and 1.
- R9: Operation code 2 (compare-exchange) compares the old value with `req_compare`. On a match it stores the operand and returns success 1. On a mismatch it issues no L1 write, leaves memory unchanged, returns success 0, and still goes through its lock and release sequence.
- R10: Size code s selects 2^s bytes (1, 2, 4 or 8). Bytes are little-endian from the request address, and bytes outside the access keep their values.
- R11: `rsp_valid` is a single-cycle pulse per accepted request, and `rsp_old` holds the value the addressed bytes had before the operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Locked operation request |
| req_ready | output | 1 | Controller idle, request may be taken |
| req_addr | input | ADDR_W | Byte address |
| req_size | input | 2 | Size code, 2^code bytes |
| req_op | input | 2 | 0 add, 1 exchange, 2 compare-exchange |
| req_operand | input | DATA_W | Addend or new value |
| req_compare | input | DATA_W | Expected value for compare-exchange |
| rsp_valid | output | 1 | Response pulse |
| rsp_old | output | DATA_W | Previous value of the addressed bytes |
| rsp_success | output | 1 | Store performed |
| l1_own_req | output | 1 | Ask for the line in an owned state |
| l1_own_gnt | input | 1 | Line is held Modified or Exclusive |
| l1_req_valid | output | 1 | L1 line access request |
| l1_req_write | output | 1 | Access is a write |
| l1_line | output | ADDR_W-6 | Line address of the access |
| l1_wdata | output | 512 | Line write data |
| l1_wmask | output | 64 | Byte write enables |
| l1_ack | input | 1 | Access done, read data valid |
| l1_rdata | input | 512 | Line read data |
| snp_valid | input | 1 | Incoming coherency snoop |
| snp_line | input | ADDR_W-6 | Snooped line address |
| snp_ready | output | 1 | Snoop may be serviced now |
| bus_lock_req | output | 1 | Request for the system bus lock |
| bus_lock_gnt | input | 1 | Bus lock granted |
| lock_out | output | 1 | System LOCK signal |
| agent_req | input | 1 | Bus request from another agent |
| agent_gnt | output | 1 | Bus grant to another agent |

## Verification
The bench aims at accesses that end exactly on a line boundary (offset 56, eight bytes) and ones that overrun it by a single byte. A design with an off-by-one crossing test would take the wrong path there, either taking the bus lock needlessly or tearing an update across two lines. Compare-exchange mismatches, including a crossing one, are checked for the absence of any write and for a lock that is still released. A design that wrote unchanged data back, or that hung in its lock state, is caught by the write count and the ready check. Snoops are held on the locked line and on an unrelated line throughout each operation, so a gate that stalls too much or too little shows up. Byte-size adds that wrap, such as 0xFF plus 1, expose writes that spill into neighbouring bytes.

// File: rtl/rmw_pkg.sv
package rmw_pkg;
   typedef enum logic [1:0] {
      OP_ADD  = 2'd0,
      OP_XCHG = 2'd1,
      OP_CMPX = 2'd2
   } rmw_op_e;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_OWN,
      ST_BREQ,
      ST_RD0,
      ST_RD1,
      ST_CALC,
      ST_WR0,
      ST_WR1,
      ST_REL
   } rmw_state_e;
endpackage

// File: rtl/rmw_lane_map.sv
module rmw_lane_map #(
   parameter int LINE_BYTES = 64,
   parameter int DATA_W     = 64,
   localparam int LW    = LINE_BYTES * 8,
   localparam int OFF_W = $clog2(LINE_BYTES),
   localparam int DB    = DATA_W / 8
) (
   input  logic [LW-1:0]         lo_line,
   input  logic [LW-1:0]         hi_line,
   input  logic [OFF_W-1:0]      offset,
   input  logic [1:0]            size,
   input  logic [DATA_W-1:0]     new_val,
   output logic [DATA_W-1:0]     old_val,
   output logic [DATA_W-1:0]     bit_mask,
   output logic [LW-1:0]         wr_lo,
   output logic [LW-1:0]         wr_hi,
   output logic [LINE_BYTES-1:0] msk_lo,
   output logic [LINE_BYTES-1:0] msk_hi
);
   logic [DB-1:0]           byte_en;
   logic [OFF_W+2:0]        shamt;
   logic [2*LW-1:0]         window, shifted, wwin;
   logic [2*LINE_BYTES-1:0] wmask;

   // per-byte enables from the size code
   for (genvar b = 0; b < DB; b++) begin : g_byte
      assign byte_en[b]         = (32'(b) < (32'd1 << size));
      assign bit_mask[b*8 +: 8] = {8{byte_en[b]}};
   end

   assign shamt   = {offset, 3'b000};
   assign window  = {hi_line, lo_line};
   assign shifted = window >> shamt;
   assign old_val = shifted[DATA_W-1:0] & bit_mask;

   assign wwin  = {{(2*LW-DATA_W){1'b0}}, new_val & bit_mask} << shamt;
   assign wmask = {{(2*LINE_BYTES-DB){1'b0}}, byte_en} << offset;

   assign wr_lo  = wwin[LW-1:0];
   assign wr_hi  = wwin[2*LW-1:LW];
   assign msk_lo = wmask[LINE_BYTES-1:0];
   assign msk_hi = wmask[2*LINE_BYTES-1:LINE_BYTES];
endmodule

// File: rtl/rmw_alu.sv
module rmw_alu
   import rmw_pkg::*;
#(
   parameter int DATA_W = 64
) (
   input  rmw_op_e           op,
   input  logic [DATA_W-1:0] old_val,
   input  logic [DATA_W-1:0] operand,
   input  logic [DATA_W-1:0] compare,
   input  logic [DATA_W-1:0] bit_mask,
   output logic [DATA_W-1:0] new_val,
   output logic              success
);
   always_comb begin
      new_val = old_val;
      success = 1'b1;
      unique case (op)
         OP_ADD:  new_val = (old_val + operand) & bit_mask;
         OP_XCHG: new_val = operand & bit_mask;
         OP_CMPX: begin
            success = (old_val == (compare & bit_mask));
            new_val = operand & bit_mask;
         end
         default: new_val = old_val;
      endcase
   end
endmodule

// File: rtl/rmw_snoop_gate.sv
module rmw_snoop_gate #(
   parameter int LINE_AW   = 26,
   parameter bit STALL_ALL = 1'b0
) (
   input  logic               defer,
   input  logic [LINE_AW-1:0] lock_line,
   input  logic               two_lines,
   input  logic [LINE_AW-1:0] snp_line,
   output logic               snp_ready
);
   logic [LINE_AW-1:0] next_line;
   logic               hit;

   assign next_line = lock_line + LINE_AW'(1);

   if (STALL_ALL) begin : g_all
      assign hit = 1'b1;
   end else begin : g_match
      assign hit = (snp_line == lock_line) || (two_lines && (snp_line == next_line));
   end

   assign snp_ready = !(defer && hit);
endmodule

// File: rtl/rmw_lock_ctrl.sv
module rmw_lock_ctrl
   import rmw_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int LINE_BYTES = 64,
   parameter int DATA_W     = 64,
   parameter bit SNP_STALL_ALL = 1'b0,
   localparam int LW      = LINE_BYTES * 8,
   localparam int OFF_W   = $clog2(LINE_BYTES),
   localparam int LINE_AW = ADDR_W - OFF_W
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  req_valid,
   output logic                  req_ready,
   input  logic [ADDR_W-1:0]     req_addr,
   input  logic [1:0]            req_size,
   input  logic [1:0]            req_op,
   input  logic [DATA_W-1:0]     req_operand,
   input  logic [DATA_W-1:0]     req_compare,
   output logic                  rsp_valid,
   output logic [DATA_W-1:0]     rsp_old,
   output logic                  rsp_success,
   output logic                  l1_own_req,
   input  logic                  l1_own_gnt,
   output logic                  l1_req_valid,
   output logic                  l1_req_write,
   output logic [LINE_AW-1:0]    l1_line,
   output logic [LW-1:0]         l1_wdata,
   output logic [LINE_BYTES-1:0] l1_wmask,
   input  logic                  l1_ack,
   input  logic [LW-1:0]         l1_rdata,
   input  logic                  snp_valid,
   input  logic [LINE_AW-1:0]    snp_line,
   output logic                  snp_ready,
   output logic                  bus_lock_req,
   input  logic                  bus_lock_gnt,
   output logic                  lock_out,
   input  logic                  agent_req,
   output logic                  agent_gnt
);
   if ((LINE_BYTES & (LINE_BYTES - 1)) != 0 || LINE_BYTES < 16) begin : g_bad_line
      $error("LINE_BYTES must be a power of two of at least 16");
   end
   if (DATA_W != 8 && DATA_W != 16 && DATA_W != 32 && DATA_W != 64) begin : g_bad_data
      $error("DATA_W must be 8, 16, 32 or 64");
   end
   if (ADDR_W <= OFF_W) begin : g_bad_addr
      $error("ADDR_W too small for the line size");
   end

   rmw_state_e          state_q;
   logic [LINE_AW-1:0]  line_q;
   logic [OFF_W-1:0]    off_q;
   logic [1:0]          size_q;
   rmw_op_e             op_q;
   logic [DATA_W-1:0]   opnd_q, cmp_q, old_q, new_q;
   logic                cross_q, succ_q;
   logic [LW-1:0]       buf0_q, buf1_q;

   logic [DATA_W-1:0]   lane_old, lane_bits, alu_new;
   logic [LW-1:0]       wr_lo, wr_hi;
   logic [LINE_BYTES-1:0] msk_lo, msk_hi;
   logic                alu_succ, req_cross, in_lock, defer;
   logic [OFF_W:0]      end_pos;

   assign end_pos   = {1'b0, req_addr[OFF_W-1:0]} + ((OFF_W+1)'(1) << req_size);
   assign req_cross = end_pos > (OFF_W+1)'(LINE_BYTES);

   rmw_lane_map #(.LINE_BYTES(LINE_BYTES), .DATA_W(DATA_W)) u_lane (
      .lo_line(buf0_q), .hi_line(buf1_q), .offset(off_q), .size(size_q),
      .new_val(new_q), .old_val(lane_old), .bit_mask(lane_bits),
      .wr_lo(wr_lo), .wr_hi(wr_hi), .msk_lo(msk_lo), .msk_hi(msk_hi));

   rmw_alu #(.DATA_W(DATA_W)) u_alu (
      .op(op_q), .old_val(lane_old), .operand(opnd_q), .compare(cmp_q),
      .bit_mask(lane_bits), .new_val(alu_new), .success(alu_succ));

   assign in_lock = (state_q == ST_RD0) || (state_q == ST_RD1) || (state_q == ST_CALC) ||
                    (state_q == ST_WR0) || (state_q == ST_WR1);
   assign defer   = in_lock;

   rmw_snoop_gate #(.LINE_AW(LINE_AW), .STALL_ALL(SNP_STALL_ALL)) u_snoop (
      .defer(defer), .lock_line(line_q), .two_lines(cross_q),
      .snp_line(snp_line), .snp_ready(snp_ready));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         line_q  <= '0;
         off_q   <= '0;
         size_q  <= '0;
         op_q    <= OP_ADD;
         opnd_q  <= '0;
         cmp_q   <= '0;
         old_q   <= '0;
         new_q   <= '0;
         cross_q <= 1'b0;
         succ_q  <= 1'b0;
         buf0_q  <= '0;
         buf1_q  <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: if (req_valid) begin
               line_q  <= req_addr[ADDR_W-1:OFF_W];
               off_q   <= req_addr[OFF_W-1:0];
               size_q  <= req_size;
               op_q    <= rmw_op_e'(req_op);
               opnd_q  <= req_operand;
               cmp_q   <= req_compare;
               cross_q <= req_cross;
               state_q <= req_cross ? ST_BREQ : ST_OWN;
            end
            ST_OWN:  if (l1_own_gnt) state_q <= ST_RD0;
            ST_BREQ: if (bus_lock_gnt) state_q <= ST_RD0;
            ST_RD0: if (l1_ack) begin
               buf0_q  <= l1_rdata;
               state_q <= cross_q ? ST_RD1 : ST_CALC;
            end
            ST_RD1: if (l1_ack) begin
               buf1_q  <= l1_rdata;
               state_q <= ST_CALC;
            end
            ST_CALC: begin
               old_q   <= lane_old;
               new_q   <= alu_new;
               succ_q  <= alu_succ;
               state_q <= alu_succ ? ST_WR0 : ST_REL;
            end
            ST_WR0: if (l1_ack) state_q <= cross_q ? ST_WR1 : ST_REL;
            ST_WR1: if (l1_ack) state_q <= ST_REL;
            ST_REL:  state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign req_ready    = (state_q == ST_IDLE);
   assign rsp_valid    = (state_q == ST_REL);
   assign rsp_old      = old_q;
   assign rsp_success  = succ_q;
   assign l1_own_req   = (state_q == ST_OWN);
   assign l1_req_valid = (state_q == ST_RD0) || (state_q == ST_RD1) ||
                         (state_q == ST_WR0) || (state_q == ST_WR1);
   assign l1_req_write = (state_q == ST_WR0) || (state_q == ST_WR1);
   assign l1_line      = ((state_q == ST_RD1) || (state_q == ST_WR1)) ?
                         line_q + LINE_AW'(1) : line_q;
   assign l1_wdata     = (state_q == ST_WR1) ? wr_hi : wr_lo;
   assign l1_wmask     = (state_q == ST_WR1) ? msk_hi : msk_lo;
   assign bus_lock_req = cross_q && (in_lock || state_q == ST_BREQ);
   assign lock_out     = cross_q && in_lock;
   assign agent_gnt    = agent_req && !lock_out;

   // one request outstanding
   assert_one_outstanding_R1: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready |=> !req_ready);
   // single-line path never touches the bus lock
   assert_own_without_lock_R2: assert property (@(posedge clk) disable iff (!rst_n)
      l1_own_req |-> !lock_out && !bus_lock_req);
   // LOCK only under a grant
   assert_lock_granted_R3: assert property (@(posedge clk) disable iff (!rst_n)
      lock_out |-> bus_lock_gnt);
   // LOCK drops only after the final write ack or a failed compare
   assert_lock_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(lock_out) |-> $past(l1_ack && l1_req_write) || $past(state_q == ST_CALC));
   // snoops to the locked line wait while the line port is active
   assert_snoop_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
      l1_req_valid && snp_valid && (snp_line == line_q) |-> !snp_ready);
   // no store after a failed compare
   assert_no_write_on_miss_R9: assert property (@(posedge clk) disable iff (!rst_n)
      l1_req_write |-> succ_q);
   // response is a pulse followed by idle
   assert_rsp_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid && req_ready);
endmodule

// File: tb/rmw_lock_ctrl_test.sv
`timescale 1ns/1ps
module rmw_lock_ctrl_test;
   localparam int ADDR_W = 32, LINE_BYTES = 64, DATA_W = 64;
   localparam int LW = LINE_BYTES * 8, LINE_AW = ADDR_W - 6;

   logic clk = 0, rst_n = 0;
   always #2.5 clk = ~clk;

   logic req_valid = 0, req_ready;
   logic [ADDR_W-1:0] req_addr = 0;
   logic [1:0] req_size = 0, req_op = 0;
   logic [DATA_W-1:0] req_operand = 0, req_compare = 0, rsp_old;
   logic rsp_valid, rsp_success, l1_own_req, l1_own_gnt = 0;
   logic l1_req_valid, l1_req_write, l1_ack = 0;
   logic [LINE_AW-1:0] l1_line, snp_line = 0;
   logic [LW-1:0] l1_wdata, l1_rdata = 0;
   logic [LINE_BYTES-1:0] l1_wmask;
   logic snp_valid = 0, snp_ready, bus_lock_req, bus_lock_gnt = 0, lock_out;
   logic agent_req = 1, agent_gnt;

   rmw_lock_ctrl #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .DATA_W(DATA_W)) uut (.*);

   logic [7:0] mem [256];
   logic [7:0] shadow [256];
   int checks = 0, errors = 0, cyc = 0;
   bit done = 0;

   // per-operation monitor state
   bit busy = 0, cur_cross = 0;
   logic [LINE_AW-1:0] cur_line = 0;
   int lock_seen, lock_bad, wr_cnt, wr_unlocked, snp_bad, own_seen, rdy_bad, agent_bad;
   int own_dly = 0, bus_dly = 0;

   task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // responders and monitor, all at the falling edge
   always @(negedge clk) begin
      if (l1_req_valid && !l1_ack) begin
         l1_ack <= 1;
         for (int b = 0; b < LINE_BYTES; b++) begin
            if (l1_req_write) begin
               if (l1_wmask[b]) mem[(int'(l1_line) % 4) * 64 + b] = l1_wdata[b*8 +: 8];
            end else l1_rdata[b*8 +: 8] <= mem[(int'(l1_line) % 4) * 64 + b];
         end
         if (l1_req_write) begin
            wr_cnt++;
            if (cur_cross && !lock_out) wr_unlocked++;
         end
      end else l1_ack <= 0;

      if (l1_own_req) begin
         if (own_dly == 0) l1_own_gnt <= 1; else own_dly--;
      end else begin
         l1_own_gnt <= 0; own_dly = $urandom % 4;
      end
      if (bus_lock_req) begin
         if (bus_dly == 0) bus_lock_gnt <= 1; else bus_dly--;
      end else begin
         bus_lock_gnt <= 0; bus_dly = $urandom % 4;
      end

      if (busy) begin
         if (lock_out) lock_seen++;
         if (lock_out && !bus_lock_gnt) lock_bad++;
         if (lock_out && agent_gnt) agent_bad++;
         if (!lock_out && agent_gnt != agent_req) agent_bad++;
         if (l1_own_req) own_seen++;
         if (req_ready && !rsp_valid) rdy_bad++;
         if (l1_req_valid && snp_valid) begin
            if (snp_ready == ((snp_line == cur_line) ||
                (cur_cross && snp_line == cur_line + 1))) snp_bad++;
         end
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !done) begin
         errors++;
         $display("FAIL watchdog R1 actual=%0d expected=%0d", cyc, 150000);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   function automatic logic [63:0] smask(input logic [1:0] s);
      return (s == 3) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << (8 << s)) - 1);
   endfunction

   function automatic logic [63:0] shadow_read(input int a, input logic [1:0] s);
      logic [63:0] v = 0;
      for (int b = 0; b < (1 << s); b++) v[b*8 +: 8] = shadow[a + b];
      return v;
   endfunction

   task automatic run_op(input int a, input logic [1:0] s, input logic [1:0] op,
                         input logic [63:0] opnd, input logic [63:0] cmpv, input bit snp_hit);
      logic [63:0] old_e, new_e;
      bit succ_e, cross_e;
      int t;
      old_e   = shadow_read(a, s);
      succ_e  = (op != 2) || (old_e == (cmpv & smask(s)));
      new_e   = (op == 0) ? ((old_e + opnd) & smask(s)) : (opnd & smask(s));
      cross_e = ((a % 64) + (1 << s)) > 64;
      if (succ_e) for (int b = 0; b < (1 << s); b++) shadow[a + b] = new_e[b*8 +: 8];

      @(negedge clk);
      lock_seen = 0; lock_bad = 0; wr_cnt = 0; wr_unlocked = 0; snp_bad = 0;
      own_seen = 0; rdy_bad = 0; agent_bad = 0;
      cur_line = LINE_AW'(a / 64); cur_cross = cross_e;
      snp_valid = 1;
      snp_line  = snp_hit ? LINE_AW'(a / 64 + (cross_e && ($urandom % 2) ? 1 : 0)) : LINE_AW'(3 - ((a/64) % 4));
      if (snp_line == cur_line || (cross_e && snp_line == cur_line + 1)) snp_line = LINE_AW'(7);
      if (snp_hit) snp_line = LINE_AW'(a / 64 + (cross_e ? 1 : 0));
      agent_req = $urandom % 2;
      req_valid = 1; req_addr = ADDR_W'(a); req_size = s; req_op = op;
      req_operand = opnd; req_compare = cmpv;
      @(negedge clk);
      req_valid = 0; busy = 1;
      t = 0;
      while (!rsp_valid && t < 200) begin @(negedge clk); t++; end
      check(rsp_valid, "R11 response arrives", 64'(rsp_valid), 1);
      check(rsp_old == old_e, "R11/R10 old value", rsp_old, old_e);
      check(rsp_success == succ_e, "R8/R9 success flag", 64'(rsp_success), 64'(succ_e));
      @(negedge clk);
      busy = 0; snp_valid = 0;
      check(!rsp_valid && req_ready, "R11 single pulse then idle", 64'(rsp_valid), 0);
      check(rdy_bad == 0, "R1 ready low while busy", 64'(rdy_bad), 0);
      check(wr_cnt == (succ_e ? (cross_e ? 2 : 1) : 0), "R9/R3 write count", 64'(wr_cnt),
            64'(succ_e ? (cross_e ? 2 : 1) : 0));
      begin
         int bad = 0;
         for (int i = 0; i < 256; i++) if (mem[i] !== shadow[i]) bad++;
         check(bad == 0, op == 0 ? "R7 memory after add" : (op == 1 ? "R8 memory after xchg" :
               "R9 memory after cmpxchg"), 64'(bad), 0);
      end
      if (cross_e) begin
         check(lock_seen > 0 && lock_bad == 0, "R3 lock under grant", 64'(lock_bad), 0);
         check(wr_unlocked == 0, "R4 writes under LOCK", 64'(wr_unlocked), 0);
      end else begin
         check(lock_seen == 0 && own_seen > 0, "R2 line path", 64'(lock_seen), 0);
      end
      check(!lock_out, "R4 LOCK released", 64'(lock_out), 0);
      check(agent_bad == 0, "R5 agent refused under LOCK", 64'(agent_bad), 0);
      check(snp_bad == 0, "R6 snoop stall", 64'(snp_bad), 0);
   endtask

   initial begin
      logic [63:0] o;
      void'($urandom(32'd1234));
      for (int i = 0; i < 256; i++) begin
         mem[i] = 8'($urandom); shadow[i] = mem[i];
      end
      repeat (3) @(negedge clk);
      check(req_ready && !rsp_valid && !lock_out && !bus_lock_req && !l1_req_valid,
            "R1 reset state", {req_ready, rsp_valid, lock_out, bus_lock_req, l1_req_valid}, 5'b10000);
      rst_n = 1;
      @(negedge clk);
      check(snp_ready && agent_gnt == agent_req, "R6 idle snoop accepted", 64'(snp_ready), 1);

      // directed corners
      run_op(56, 3, 0, 64'h1, 0, 1);              // ends exactly at boundary: no cross (R2)
      run_op(60, 3, 1, 64'hA5A5_1234_5678_9ABC, 0, 1); // crosses (R3 R8)
      run_op(127, 1, 0, 64'h0101, 0, 1);          // one byte over (R3 R7)
      shadow[10] = 8'hFF; mem[10] = 8'hFF;
      run_op(10, 0, 0, 64'h1, 0, 0);              // byte wrap (R10)
      o = shadow_read(62, 2);
      run_op(62, 2, 2, 64'h5555_5555, ~o, 1);     // crossing mismatch (R9)
      o = shadow_read(62, 2);
      run_op(62, 2, 2, 64'h1357_2468, o, 0);      // crossing match (R9)
      o = shadow_read(16, 3);
      run_op(16, 3, 2, 64'hDEAD_BEEF, o ^ 64'h100, 1); // line mismatch (R9)
      run_op(33, 1, 1, 64'hBEEF, 0, 1);           // misaligned inside line (R10)

      for (int n = 0; n < 40; n++) begin
         int a; logic [1:0] s, op; logic [63:0] cv;
         a = $urandom % 240; s = 2'($urandom % 4); op = 2'($urandom % 3);
         cv = ($urandom % 2) ? shadow_read(a, s) : {$urandom, $urandom};
         run_op(a, s, op, {$urandom, $urandom}, cv, 1'($urandom % 2));
      end
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule